// File: doc/BRIEF.md
# Store Queue Entry Tracker

This block keeps the store side of the memory ordering buffer in an out-of-order core. The dispatch stage allocates one entry per store at the tail of a circular queue and tags it with the store's sequence number. When the store's address stage finishes, the execute side records the access size and the data word through a separate write port that is indexed by entry number. Commit hands in a sequence number and every older store still waiting is then committed and becomes eligible for writeback.

Writeback leaves in program order through a single data cache port. A dedicated writeback pointer walks the committed stores, and a store is issued in the cycle its entry is committed and not yet done, unless the cache reports that it is blocked. Cache acknowledgements come back by entry index, in any order. An entry is released at the head only once its own acknowledgement has arrived, so a committed store keeps its slot until the cache has accepted it. A squash sequence number removes younger, uncommitted stores from the tail, one entry per cycle.

The block reports the number of committed stores still awaiting writeback, the number of uncommitted stores, a full flag, the free-slot figure handed up to dispatch, whether a squash walk is in progress, and the head and tail indices.

Top module: `storeQueueTracker`

## Requirements
- R1: After reset the queue is empty: headIdx, tailIdx and the writeback pointer are 0, both counts are 0, full, wbFire and squashBusy are low, and freeCount equals the smaller of freeLoads and DEPTH-1.
- R2: A store that is allocated while the queue is not full and no squash walk is running takes the entry at tailIdx. At that edge its size, data and the committed, can-write-back and completed flags are cleared, tailIdx advances by one with wrap at DEPTH, and activeCount rises by one.
- R3: full is high exactly when activeCount plus wbPendCount is at least DEPTH-1. An allocation request while full is high, or while squashBusy is high, has no effect on tailIdx or on the counts.
- R4: A write-port strobe stores wrSize and wrData into entry wrIdx, and these values are presented on wbSize and wbData when that entry is issued for writeback.
- R5: A commit strobe marks as committed and able to write back every valid, uncommitted entry whose sequence number is less than or equal to commitSeq (unsigned compare). At the same edge activeCount falls and wbPendCount rises by the number of entries marked.
- R6: wbFire is high in a cycle exactly when the entry at the writeback pointer is valid, can write back, is not completed, and cacheBlocked is low. wbIdx always shows the pointer, which advances by one at each edge where wbFire is high.
- R7: A completion strobe marks entry cplIdx completed. From the next edge on, at each edge where the entry at headIdx is valid and completed, it is released: headIdx advances by one and wbPendCount falls by one. Commit alone never releases an entry.
- R8: An entry completed before the entries older than it stays in the queue, and headIdx does not move, until the entry at headIdx itself is completed.
- R9: A squash strobe latches its bound, and squashBusy is high from the next cycle. In each busy cycle the entry just below tailIdx is removed (tailIdx and activeCount fall by one) if it is valid, uncommitted, not being committed in that cycle, and has a sequence number greater than the bound. Otherwise the walk ends. A squash strobe during a walk keeps it running with the smaller of the two bounds.
- R10: freeCount equals the smaller of freeLoads and DEPTH-1 minus (activeCount plus wbPendCount).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate one store entry at the tail |
| allocSeq | input | SEQ_W | Sequence number of the allocated store |
| wrValid | input | 1 | Record size and data into an entry |
| wrIdx | input | IDX_W | Entry written by the write port |
| wrSize | input | SIZE_W | Access size in bytes |
| wrData | input | DATA_W | Store data word |
| commitValid | input | 1 | Commit stores up to commitSeq |
| commitSeq | input | SEQ_W | Youngest sequence number to commit |
| squashValid | input | 1 | Start or extend a squash walk |
| squashSeq | input | SEQ_W | Stores younger than this are removed |
| cacheBlocked | input | 1 | Data cache cannot accept a write this cycle |
| cplValid | input | 1 | Writeback acknowledgement |
| cplIdx | input | IDX_W | Entry whose writeback completed |
| freeLoads | input | CNT_W | Free load entries reported by the load side |
| wbFire | output | 1 | A store writeback is issued this cycle |
| wbIdx | output | IDX_W | Entry at the writeback pointer |
| wbSize | output | SIZE_W | Size of the entry at the writeback pointer |
| wbData | output | DATA_W | Data of the entry at the writeback pointer |
| full | output | 1 | Occupancy has reached DEPTH-1 |
| activeCount | output | CNT_W | Held stores not yet committed |
| wbPendCount | output | CNT_W | Committed stores still holding an entry |
| freeCount | output | CNT_W | Free-slot figure for dispatch |
| headIdx | output | IDX_W | Oldest held entry |
| tailIdx | output | IDX_W | Next entry to allocate |
| squashBusy | output | 1 | A squash walk is in progress |

## Verification
The pointers and the two counts must agree with the number of valid entries, so a bad update shows at the ports within a cycle. A lost count moves full and freeCount at the wrong time. A pointer off by one sends the wrong wbIdx, or sends wbData from a slot that was never written, at the next writeback. A head that moves too early drops wbPendCount while an acknowledgement is still missing. A squash that passes a committed store, or stops early, leaves tailIdx and activeCount wrong in the cycle after the walk ends, and the next allocation then lands at the wrong index.

// File: rtl/storeQueuePkg.sv
package storeQueuePkg;

  // Strobes from the control module into the entry array for one cycle.
  typedef struct packed {
    logic alloc;       // fill the entry at the tail
    logic free;        // release the entry at the head
    logic removeTail;  // squash the entry just below the tail
    logic commit;      // apply the commit compare this cycle
  } sqStrobe_t;

endpackage

// File: rtl/sqEntries.sv
module sqEntries
  import storeQueuePkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqStrobe_t         strobe,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [IDX_W-1:0]  probeIdx,
  input  logic [IDX_W-1:0]  wbIdx,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cplValid,
  input  logic [IDX_W-1:0]  cplIdx,
  output logic [DEPTH-1:0]  validV,
  output logic [DEPTH-1:0]  committedV,
  output logic [DEPTH-1:0]  canWbV,
  output logic [DEPTH-1:0]  completedV,
  output logic [DEPTH-1:0]  commitHitV,
  output logic [SEQ_W-1:0]  probeSeq,
  output logic [SIZE_W-1:0] wbSize,
  output logic [DATA_W-1:0] wbData
);

  logic [SEQ_W-1:0]  seqQ  [DEPTH];
  logic [SIZE_W-1:0] sizeQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];

  // Commit compare: every held, uncommitted entry at or below the bound.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      commitHitV[i] = strobe.commit && validV[i] && !committedV[i] &&
                      (seqQ[i] <= commitSeq);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validV     <= '0;
      committedV <= '0;
      canWbV     <= '0;
      completedV <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seqQ[i]  <= '0;
        sizeQ[i] <= '0;
        dataQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrValid && wrIdx == IDX_W'(i)) begin
          sizeQ[i] <= wrSize;
          dataQ[i] <= wrData;
        end
        if (cplValid && cplIdx == IDX_W'(i)) completedV[i] <= 1'b1;
        if (commitHitV[i]) begin
          committedV[i] <= 1'b1;
          canWbV[i]     <= 1'b1;
        end
        if (strobe.free && headIdx == IDX_W'(i)) validV[i] <= 1'b0;
        if (strobe.removeTail && probeIdx == IDX_W'(i)) validV[i] <= 1'b0;
        // Allocation last: a fresh entry starts with every field cleared.
        if (strobe.alloc && tailIdx == IDX_W'(i)) begin
          validV[i]     <= 1'b1;
          seqQ[i]       <= allocSeq;
          committedV[i] <= 1'b0;
          canWbV[i]     <= 1'b0;
          completedV[i] <= 1'b0;
          sizeQ[i]      <= '0;
          dataQ[i]      <= '0;
        end
      end
    end
  end

  assign probeSeq = seqQ[probeIdx];
  assign wbSize   = sizeQ[wbIdx];
  assign wbData   = dataQ[wbIdx];

  // R5: once committed, an entry stays committed for as long as it is held.
  for (genvar g = 0; g < DEPTH; g++) begin : gSticky
    p_commit_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
      (validV[g] && committedV[g]) |=> (committedV[g] || !validV[g]));
  end

endmodule

// File: rtl/sqControl.sv
module sqControl
  import storeQueuePkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             commitValid,
  input  logic             squashValid,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic             cacheBlocked,
  input  logic [CNT_W-1:0] freeLoads,
  input  logic [DEPTH-1:0] validV,
  input  logic [DEPTH-1:0] committedV,
  input  logic [DEPTH-1:0] canWbV,
  input  logic [DEPTH-1:0] completedV,
  input  logic [DEPTH-1:0] commitHitV,
  input  logic [SEQ_W-1:0] probeSeq,
  output sqStrobe_t        strobe,
  output logic [IDX_W-1:0] headQ,
  output logic [IDX_W-1:0] tailQ,
  output logic [IDX_W-1:0] wbQ,
  output logic [IDX_W-1:0] probeIdx,
  output logic [CNT_W-1:0] activeQ,
  output logic [CNT_W-1:0] pendQ,
  output logic             full,
  output logic             wbFire,
  output logic             squashBusy,
  output logic [CNT_W-1:0] freeCount
);

  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] p);
    return (p == LAST_IX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] prevIdx(input logic [IDX_W-1:0] p);
    return (p == '0) ? LAST_IX : p - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] popCount(input logic [DEPTH-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic [SEQ_W-1:0] squashBoundQ;
  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] storeFree;
  logic [CNT_W-1:0] commitCnt;

  assign occ       = activeQ + pendQ;
  assign full      = (occ >= LIMIT);
  assign storeFree = LIMIT - occ;
  assign freeCount = (freeLoads < storeFree) ? freeLoads : storeFree;
  assign commitCnt = popCount(commitHitV);
  assign probeIdx  = prevIdx(tailQ);
  assign squashBusy = (squashQ == 1'b1);

  logic squashQ;

  // Writeback issue: oldest committed, unfinished store, cache willing.
  assign wbFire = validV[wbQ] && canWbV[wbQ] && !completedV[wbQ] && !cacheBlocked;

  always_comb begin
    strobe            = '0;
    strobe.commit     = commitValid;
    strobe.alloc      = allocValid && !full && !squashQ;
    strobe.free       = validV[headQ] && completedV[headQ];
    strobe.removeTail = squashQ && validV[probeIdx] && !committedV[probeIdx] &&
                        !commitHitV[probeIdx] && (probeSeq > squashBoundQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ        <= '0;
      tailQ        <= '0;
      wbQ          <= '0;
      activeQ      <= '0;
      pendQ        <= '0;
      squashQ      <= 1'b0;
      squashBoundQ <= '0;
    end else begin
      if (strobe.free) headQ <= nextIdx(headQ);
      if (strobe.removeTail)  tailQ <= probeIdx;
      else if (strobe.alloc)  tailQ <= nextIdx(tailQ);
      if (wbFire) wbQ <= nextIdx(wbQ);
      activeQ <= activeQ + CNT_W'(strobe.alloc) - commitCnt - CNT_W'(strobe.removeTail);
      pendQ   <= pendQ + commitCnt - CNT_W'(strobe.free);
      if (squashValid) begin
        squashQ      <= 1'b1;
        squashBoundQ <= (squashQ && squashBoundQ < squashSeq) ? squashBoundQ : squashSeq;
      end else if (squashQ && !strobe.removeTail) begin
        squashQ <= 1'b0;
      end
    end
  end

  // R3: the held count never passes the one-slot-empty limit.
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= LIMIT);

  // R3: a request while full leaves the tail where it was.
  p_full_blocks_alloc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && full && !squashQ) |=> $stable(tailQ));

  // R2: pointer distance and the two counts describe the same occupancy.
  p_ptr_count_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(tailQ) - int'(headQ) + DEPTH) % DEPTH) == int'(occ));

  // R6: the writeback pointer moves by exactly one per issued store.
  p_wb_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbFire |=> (wbQ == nextIdx($past(wbQ))));
  p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wbFire |=> $stable(wbQ));

  // R9: while a squash walk runs, the uncommitted count cannot grow.
  p_squash_no_growth_r9: assert property (@(posedge clk) disable iff (!rstN)
    squashQ |=> (activeQ <= $past(activeQ)));

endmodule

// File: rtl/storeQueueTracker.sv
module storeQueueTracker
  import storeQueuePkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [DATA_W-1:0] wrData,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              cacheBlocked,
  input  logic              cplValid,
  input  logic [IDX_W-1:0]  cplIdx,
  input  logic [CNT_W-1:0]  freeLoads,
  output logic              wbFire,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [SIZE_W-1:0] wbSize,
  output logic [DATA_W-1:0] wbData,
  output logic              full,
  output logic [CNT_W-1:0]  activeCount,
  output logic [CNT_W-1:0]  wbPendCount,
  output logic [CNT_W-1:0]  freeCount,
  output logic [IDX_W-1:0]  headIdx,
  output logic [IDX_W-1:0]  tailIdx,
  output logic              squashBusy
);

  sqStrobe_t        strobe;
  logic [IDX_W-1:0] probeIdx;
  logic [DEPTH-1:0] validV, committedV, canWbV, completedV, commitHitV;
  logic [SEQ_W-1:0] probeSeq;

  sqControl #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .commitValid(commitValid),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .cacheBlocked(cacheBlocked), .freeLoads(freeLoads),
    .validV(validV), .committedV(committedV), .canWbV(canWbV),
    .completedV(completedV), .commitHitV(commitHitV), .probeSeq(probeSeq),
    .strobe(strobe), .headQ(headIdx), .tailQ(tailIdx), .wbQ(wbIdx),
    .probeIdx(probeIdx), .activeQ(activeCount), .pendQ(wbPendCount),
    .full(full), .wbFire(wbFire), .squashBusy(squashBusy),
    .freeCount(freeCount)
  );

  sqEntries #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headIdx(headIdx), .tailIdx(tailIdx), .probeIdx(probeIdx), .wbIdx(wbIdx),
    .allocSeq(allocSeq), .commitSeq(commitSeq),
    .wrValid(wrValid), .wrIdx(wrIdx), .wrSize(wrSize), .wrData(wrData),
    .cplValid(cplValid), .cplIdx(cplIdx),
    .validV(validV), .committedV(committedV), .canWbV(canWbV),
    .completedV(completedV), .commitHitV(commitHitV),
    .probeSeq(probeSeq), .wbSize(wbSize), .wbData(wbData)
  );

endmodule

// File: tb/storeQueueTracker_test.sv
`timescale 1ns/1ps
module storeQueueTracker_test;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid, wrValid, commitValid, squashValid, cacheBlocked, cplValid;
  logic [15:0] allocSeq, commitSeq, squashSeq;
  logic [2:0]  wrIdx, cplIdx;
  logic [3:0]  wrSize, freeLoads;
  logic [63:0] wrData;
  logic        wbFire, full, squashBusy;
  logic [2:0]  wbIdx, headIdx, tailIdx;
  logic [3:0]  wbSize, activeCount, wbPendCount, freeCount;
  logic [63:0] wbData;

  always #2.5 clk = ~clk;

  storeQueueTracker uut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocSeq(allocSeq),
    .wrValid(wrValid), .wrIdx(wrIdx), .wrSize(wrSize), .wrData(wrData),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .cacheBlocked(cacheBlocked), .cplValid(cplValid), .cplIdx(cplIdx),
    .freeLoads(freeLoads), .wbFire(wbFire), .wbIdx(wbIdx), .wbSize(wbSize),
    .wbData(wbData), .full(full), .activeCount(activeCount),
    .wbPendCount(wbPendCount), .freeCount(freeCount), .headIdx(headIdx),
    .tailIdx(tailIdx), .squashBusy(squashBusy)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference model state
  bit mv[D], mcom[D], mcw[D], mcp[D];
  int mseq[D], msize[D];
  logic [63:0] mdata[D];
  int mh, mt, mw, mact, mpend, msqSeq, nextSeq;
  bit msq;
  int outq[$];

  task automatic check(string req, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    allocValid = 0; wrValid = 0; commitValid = 0; squashValid = 0;
    cacheBlocked = 0; cplValid = 0; allocSeq = 16'(nextSeq);
    commitSeq = 0; squashSeq = 0; wrIdx = 0; cplIdx = 0; wrSize = 0;
    wrData = 0; freeLoads = 4'd15;
  endtask

  function automatic int minI(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic compareAll();
    bit ef;
    ef = mv[mw] && mcw[mw] && !mcp[mw] && !cacheBlocked;
    check("R6 wbFire", wbFire, ef);
    check("R6 wbIdx", wbIdx, mw);
    if (ef) begin
      check("R4 wbData", wbData, mdata[mw]);
      check("R4 wbSize", wbSize, msize[mw]);
    end
    check("R3 full", full, (mact + mpend) >= D - 1);
    check("R5 activeCount", activeCount, mact);
    check("R7 wbPendCount", wbPendCount, mpend);
    check("R10 freeCount", freeCount, minI(int'(freeLoads), D - 1 - mact - mpend));
    check("R7 headIdx", headIdx, mh);
    check("R2 tailIdx", tailIdx, mt);
    check("R9 squashBusy", squashBusy, msq);
  endtask

  task automatic modelStep();
    bit hit[D];
    int n, pr;
    bit fire, fr, rm, al;
    n = 0;
    fire = mv[mw] && mcw[mw] && !mcp[mw] && !cacheBlocked;
    for (int i = 0; i < D; i++) begin
      hit[i] = commitValid && mv[i] && !mcom[i] && (mseq[i] <= int'(commitSeq));
      n += int'(hit[i]);
    end
    fr = mv[mh] && mcp[mh];
    pr = (mt + D - 1) % D;
    rm = msq && mv[pr] && !mcom[pr] && !hit[pr] && (mseq[pr] > msqSeq);
    al = allocValid && ((mact + mpend) < D - 1) && !msq;
    if (wrValid) begin msize[wrIdx] = int'(wrSize); mdata[wrIdx] = wrData; end
    if (cplValid) mcp[cplIdx] = 1;
    for (int i = 0; i < D; i++) if (hit[i]) begin mcom[i] = 1; mcw[i] = 1; end
    if (fr) begin mv[mh] = 0; mh = (mh + 1) % D; end
    if (rm) begin mv[pr] = 0; mt = pr; end
    if (al) begin
      mv[mt] = 1; mseq[mt] = int'(allocSeq); mcom[mt] = 0; mcw[mt] = 0;
      mcp[mt] = 0; msize[mt] = 0; mdata[mt] = 0; mt = (mt + 1) % D;
      nextSeq++;
    end
    if (fire) begin outq.push_back(mw); mw = (mw + 1) % D; end
    mact = mact + int'(al) - n - int'(rm);
    mpend = mpend + n - int'(fr);
    if (squashValid) begin
      msqSeq = (msq && msqSeq < int'(squashSeq)) ? msqSeq : int'(squashSeq);
      msq = 1;
    end else if (msq && !rm) msq = 0;
  endtask

  task automatic cycle();
    #1;
    compareAll();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic complete(int idx);
    cplValid = 1; cplIdx = 3'(idx);
    for (int k = 0; k < outq.size(); k++)
      if (outq[k] == idx) begin outq.delete(k); break; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5a17);
    nextSeq = 1;
    for (int i = 0; i < D; i++) begin
      mv[i] = 0; mcom[i] = 0; mcw[i] = 0; mcp[i] = 0;
      mseq[i] = 0; msize[i] = 0; mdata[i] = 0;
    end
    mh = 0; mt = 0; mw = 0; mact = 0; mpend = 0; msq = 0; msqSeq = 0;
    idle();
    freeLoads = 4'd12;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state at the ports
    check("R1 headIdx", headIdx, 0);
    check("R1 tailIdx", tailIdx, 0);
    check("R1 wbIdx", wbIdx, 0);
    check("R1 counts", {activeCount, wbPendCount}, 0);
    check("R1 flags", {full, wbFire, squashBusy}, 0);
    check("R1 freeCount", freeCount, 7);
    @(negedge clk);
    idle();

    // R2/R4: allocate seven stores, each written right after allocation
    for (int i = 0; i < 7; i++) begin
      allocValid = 1; allocSeq = 16'(nextSeq);
      if (i > 0) begin
        wrValid = 1; wrIdx = 3'(i - 1); wrSize = 4'd8;
        wrData = 64'h1111_0000_0000_0000 + 64'(i - 1);
      end
      cycle();
    end
    wrValid = 1; wrIdx = 3'd6; wrSize = 4'd4; wrData = 64'hbeef;
    cycle();
    // R3: full blocks a further allocation
    allocValid = 1; allocSeq = 16'(nextSeq);
    cycle();
    check("R3 tail held while full", tailIdx, 7);
    // R5: commit up to sequence 3
    commitValid = 1; commitSeq = 16'd3;
    cycle();
    check("R5 committed three", {activeCount, wbPendCount}, {4'd4, 4'd3});
    cacheBlocked = 1;
    cycle();
    repeat (3) cycle();
    // R8: entry 1 completed ahead of entry 0
    complete(1);
    cycle();
    cycle();
    check("R8 head waits for oldest", headIdx, 0);
    complete(0);
    cycle();
    cycle();
    cycle();
    check("R7 head released two", headIdx, 2);
    // R9: squash above sequence 4 removes entries 4..6 only
    squashValid = 1; squashSeq = 16'd4;
    cycle();
    repeat (5) cycle();
    check("R9 tail after squash", tailIdx, 4);
    check("R9 active after squash", activeCount, 1);
    complete(2);
    cycle();

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      allocValid = ($urandom % 3) != 0;
      allocSeq = 16'(nextSeq);
      if ($urandom % 2 == 0) begin
        wrValid = 1; wrIdx = 3'($urandom % D);
        wrSize = 4'(1 + $urandom % 8); wrData = {$urandom, $urandom};
      end
      if ($urandom % 5 == 0) begin
        commitValid = 1;
        commitSeq = 16'(minI(nextSeq, nextSeq - 1 - int'($urandom % 6)) < 0 ? 0 :
                        nextSeq - 1 - int'($urandom % 6));
      end
      cacheBlocked = ($urandom % 4) == 0;
      if (outq.size() > 0 && $urandom % 3 == 0)
        complete(outq[$urandom % outq.size()]);
      if (!msq && $urandom % 40 == 0) begin
        squashValid = 1;
        squashSeq = 16'((nextSeq > 6) ? nextSeq - 1 - int'($urandom % 5) : 0);
      end
      freeLoads = 4'($urandom % 16);
      cycle();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule